// File: doc/BRIEF.md
# Dual-Host Banked Watchdog Timer

This block provides one independent watchdog for each of two host processors behind a single small register window. Every access carries a host identifier. The identifier picks the bank, so each host works with its own watchdog at the same offsets and cannot reach the other one. A watchdog counts down an 18-bit timeout in steps of one millisecond tick. When the count runs out, that host's timeout output is raised and held.

The reload value is built from three pieces. The two most significant bits come from the control register. The middle byte comes from a holding register. The low byte is the data of the trigger write itself. A trigger write copies the whole value into the counter and restarts the countdown. Software can set the enable bit but cannot clear it. Only loss of power-good, the host's own reset or the global reset clears it. A debug strap freezes every countdown and forces the timeout outputs low.

Each bank runs a three-state machine:
- `WD_IDLE` means not enabled.
- `WD_RUN` means enabled and counting.
- `WD_EXPIRED` means the timeout has fired.

The transitions are:
- `arm`: from `WD_IDLE` to `WD_RUN`, when a control write has bit 7 set.
- `fire`: from `WD_RUN` to `WD_EXPIRED`, on the tick that ends the count.
- `clear`: from any state to `WD_IDLE`, on the bank's reset.

Top module: `wdt_dual_bank`

## Requirements
- R1: An access with `req_host` = h reads or writes only bank h. The other bank's registers, counter and timeout are unaffected.
- R2: A write to offset 0x18 loads the counter with {control bits 1:0, holding register, write data}, using the register values held before that cycle. A read of 0x18 returns 0.
- R3: Control register at offset 0x19: bits 1:0 are read/write and reset to 2'b11, and bits 6:2 read as 0.
- R4: Control bit 7 is the enable and resets to 0. Writing 1 sets it and writing 0 has no effect. It is cleared only by `rst_n`, by `pwr_good` low or by that host's `host_rst` bit.
- R5: The holding register at offset 0x1A is read/write, resets to 0xFF, and supplies timeout bits 15:8.
- R6: While enabled and not expired, the counter drops by one on each cycle with `tick_1ms` high. With no tick it holds.
- R7: A tick that finds the counter at 1 or 0 while running sets that host's `timeout` in the next cycle. `timeout` then stays high until a bank reset, and a trigger write does not clear it.
- R8: A trigger write while the bank is disabled loads the counter. No ticks are counted until the enable is set.
- R9: While `dbg_disable` is high, no counter decrements and every `timeout` bit is 0.
- R10: A read (`req_valid` high, `req_write` low) gives `rd_valid` and `rd_data` one cycle later. Offsets other than 0x18 to 0x1A read 0. In cycles without a read, `rd_valid` and `rd_data` are 0.
- R11: While enabled, the control bits and holding register may still be written, and a new trigger write reloads and restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| pwr_good | input | 1 | Power good; low clears both banks |
| host_rst | input | 2 | Per-host synchronous reset, bit h clears bank h |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| dbg_disable | input | 1 | Debug strap: freezes counting, masks timeouts |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_host | input | 1 | Identifier of the requesting host |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 8 | Read data |
| timeout | output | 2 | Per-host expiry flag |

## Verification
The counter cannot be seen directly. A wrong count therefore shows up as a `timeout` edge that arrives early or late, measured in ticks after the trigger. That edge appears in the cycle right after the deciding tick, so the error is visible as soon as the model expects the edge. A wrong enable, holding or top-bit value appears on the next read of the control or holding offset. Cross-bank leakage appears as a read or a timeout edge on the host that did not make the access. The bench runs a per-host model in step with the design and compares every port on every cycle, so a diverging state is reported within one cycle of becoming visible.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_IDLE     = 2'd0,
        WD_RUN      = 2'd1,
        WD_EXPIRED  = 2'd2
    } wd_state_e;

    // Register offsets within the shared window
    localparam logic [7:0] OFS_TRIG = 8'h18;
    localparam logic [7:0] OFS_CTRL = 8'h19;
    localparam logic [7:0] OFS_HOLD = 8'h1A;

    // Read-select encoding (one-hot)
    localparam int SEL_TRIG = 0;
    localparam int SEL_CTRL = 1;
    localparam int SEL_HOLD = 2;
    localparam int SEL_W    = 3;
endpackage

// File: rtl/wdt_reg_decode.sv
module wdt_reg_decode
    import wdt_pkg::*;
#(
    parameter int NUM_HOSTS = 2,
    parameter int ADDR_W    = 8,
    parameter int HID_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [HID_W-1:0]     req_host,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic [NUM_HOSTS-1:0] we_trig,
    output logic [NUM_HOSTS-1:0] we_ctrl,
    output logic [NUM_HOSTS-1:0] we_hold,
    output logic [SEL_W-1:0]     rd_sel,
    output logic                 rd_en
);
    logic hit_trig, hit_ctrl, hit_hold, wr;

    always_comb begin
        hit_trig = (req_addr == ADDR_W'(OFS_TRIG));
        hit_ctrl = (req_addr == ADDR_W'(OFS_CTRL));
        hit_hold = (req_addr == ADDR_W'(OFS_HOLD));
        wr       = req_valid && req_write;
        rd_en    = req_valid && !req_write;
        rd_sel   = '0;
        rd_sel[SEL_TRIG] = hit_trig;
        rd_sel[SEL_CTRL] = hit_ctrl;
        rd_sel[SEL_HOLD] = hit_hold;
    end

    // The requesting host alone selects the bank
    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
        logic own;
        assign own        = (req_host == HID_W'(h));
        assign we_trig[h] = wr && hit_trig && own;
        assign we_ctrl[h] = wr && hit_ctrl && own;
        assign we_hold[h] = wr && hit_hold && own;
    end

    // R1: one access reaches at most one register of one bank
    p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_trig, we_ctrl, we_hold}))
        else $error("p_one_target_r1");
endmodule

// File: rtl/wdt_bank.sv
module wdt_bank
    import wdt_pkg::*;
#(
    parameter int TMO_W  = 18,
    parameter int DATA_W = 8,
    parameter int MSB_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              dbg,
    input  logic              we_trig,
    input  logic              we_ctrl,
    input  logic              we_hold,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_val,
    output logic              expired_o
);
    localparam int MID_W  = TMO_W - DATA_W - MSB_W;
    localparam int PAD_W  = DATA_W - 1 - MSB_W;
    localparam int EN_BIT = DATA_W - 1;

    wd_state_e        state_q, state_d;
    logic [MSB_W-1:0] msb_q;
    logic [MID_W-1:0] hold_q;
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] reload;
    logic             cnt_step, last_tick, enabled;

    assign reload    = {msb_q, hold_q, wdata};
    assign cnt_step  = (state_q == WD_RUN) && tick && !dbg && !we_trig;
    assign last_tick = (cnt_q <= TMO_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= WD_IDLE;
        else if (clr) state_q <= WD_IDLE;
        else          state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:    if (we_ctrl && wdata[EN_BIT]) state_d = WD_RUN;
            WD_RUN:     if (cnt_step && last_tick)    state_d = WD_EXPIRED;
            WD_EXPIRED: state_d = WD_EXPIRED;
            default:    state_d = WD_IDLE;
        endcase
    end

    // Software-visible fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msb_q  <= '1;
            hold_q <= '1;
        end else if (clr) begin
            msb_q  <= '1;
            hold_q <= '1;
        end else begin
            if (we_ctrl) msb_q  <= wdata[MSB_W-1:0];
            if (we_hold) hold_q <= wdata[MID_W-1:0];
        end
    end

    // Countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '1;
        else if (clr)      cnt_q <= '1;
        else if (we_trig)  cnt_q <= reload;
        else if (cnt_step) cnt_q <= last_tick ? '0 : cnt_q - TMO_W'(1);
    end

    // Outputs
    always_comb begin
        enabled   = (state_q != WD_IDLE);
        expired_o = (state_q == WD_EXPIRED);
        rd_val    = '0;
        if (rd_sel[SEL_CTRL])      rd_val = {enabled, {PAD_W{1'b0}}, msb_q};
        else if (rd_sel[SEL_HOLD]) rd_val = DATA_W'(hold_q);
    end

    // R4: enable never drops without a bank reset
    p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WD_IDLE) && !clr |=> (state_q != WD_IDLE))
        else $error("p_enable_sticky_r4");

    // R7: expiry holds until a bank reset
    p_expired_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_EXPIRED) && !clr |=> (state_q == WD_EXPIRED))
        else $error("p_expired_sticky_r7");

    // R6: a running count drops by exactly one per tick
    p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_step && !clr && !last_tick |=> (cnt_q == $past(cnt_q) - TMO_W'(1)))
        else $error("p_decrement_r6");

    // R6 R8 R9: without tick, enable or with debug, the count stays put
    p_hold_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !we_trig && (!tick || dbg || state_q != WD_RUN) |=> $stable(cnt_q))
        else $error("p_hold_count_r8");

    // R9: debug strap prevents a new expiry
    p_no_fire_dbg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg && (state_q != WD_EXPIRED) |=> (state_q != WD_EXPIRED))
        else $error("p_no_fire_dbg_r9");

    // R3 R5: a bank reset restores field defaults
    p_clr_defaults_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (msb_q == '1) && (hold_q == '1) && (state_q == WD_IDLE))
        else $error("p_clr_defaults_r3");
endmodule

// File: rtl/wdt_dual_bank.sv
module wdt_dual_bank
    import wdt_pkg::*;
#(
    parameter int NUM_HOSTS = 2,
    parameter int TMO_W     = 18,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    localparam int HID_W    = (NUM_HOSTS > 1) ? $clog2(NUM_HOSTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_good,
    input  logic [NUM_HOSTS-1:0] host_rst,
    input  logic                 tick_1ms,
    input  logic                 dbg_disable,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [HID_W-1:0]     req_host,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_HOSTS-1:0] timeout
);
    logic [NUM_HOSTS-1:0] we_trig, we_ctrl, we_hold, expired;
    logic [SEL_W-1:0]     rd_sel;
    logic                 rd_en;
    logic [DATA_W-1:0]    bank_rd [NUM_HOSTS];

    wdt_reg_decode #(
        .NUM_HOSTS (NUM_HOSTS),
        .ADDR_W    (ADDR_W),
        .HID_W     (HID_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_host  (req_host),
        .req_addr  (req_addr),
        .we_trig   (we_trig),
        .we_ctrl   (we_ctrl),
        .we_hold   (we_hold),
        .rd_sel    (rd_sel),
        .rd_en     (rd_en)
    );

    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_bank
        wdt_bank #(
            .TMO_W  (TMO_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (!pwr_good || host_rst[h]),
            .tick      (tick_1ms),
            .dbg       (dbg_disable),
            .we_trig   (we_trig[h]),
            .we_ctrl   (we_ctrl[h]),
            .we_hold   (we_hold[h]),
            .wdata     (req_wdata),
            .rd_sel    (rd_sel),
            .rd_val    (bank_rd[h]),
            .expired_o (expired[h])
        );
    end

    assign timeout = dbg_disable ? '0 : expired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? bank_rd[req_host] : '0;
        end
    end

    // R10: a read is answered in the following cycle
    p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rd_valid)
        else $error("p_rd_latency_r10");

    // R10: idle read port stays quiet
    p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid && (rd_data == '0))
        else $error("p_rd_quiet_r10");

    // R2: the trigger offset always reads as zero
    p_trig_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && (req_addr == ADDR_W'(OFS_TRIG)) |=> (rd_data == '0))
        else $error("p_trig_reads_zero_r2");
endmodule

// File: tb/tb_wdt_dual_bank.sv
`timescale 1ns/1ps
module tb_wdt_dual_bank;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_good;
    logic [1:0] host_rst;
    logic       tick_1ms;
    logic       dbg_disable;
    logic       req_valid, req_write, req_host;
    logic [7:0] req_addr, req_wdata;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [1:0] timeout;

    always #2.5 clk = ~clk;

    wdt_dual_bank dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .host_rst(host_rst),
        .tick_1ms(tick_1ms), .dbg_disable(dbg_disable),
        .req_valid(req_valid), .req_write(req_write), .req_host(req_host),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .timeout(timeout)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string ctx = "reset";

    // Per-host model
    logic       m_en   [2];
    logic       m_exp  [2];
    int         m_cnt  [2];
    logic [1:0] m_msb  [2];
    logic [7:0] m_hold [2];

    function automatic logic [7:0] exp_read(int h, logic [7:0] a);
        if (a == 8'h19)      return {m_en[h], 5'b0, m_msb[h]};
        else if (a == 8'h1A) return m_hold[h];
        else                 return 8'h00;
    endfunction

    function automatic string tag_for(logic [7:0] a);
        if (a == 8'h18)      return "R2";
        else if (a == 8'h19) return "R3 R4";
        else if (a == 8'h1A) return "R5";
        else                 return "R10";
    endfunction

    task automatic model_reset(int h);
        m_en[h] = 0; m_exp[h] = 0; m_cnt[h] = 32'h3FFFF;
        m_msb[h] = 2'b11; m_hold[h] = 8'hFF;
    endtask

    task automatic chk(logic [7:0] got, logic [7:0] exp, string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s [%s] got %h expected %h", tag, ctx, got, exp);
        end
    endtask

    // One clock cycle: drive, update model, compare every output
    task automatic cyc(logic v, logic w, logic h, logic [7:0] a, logic [7:0] d,
                       logic tk, logic dbg, logic pg, logic [1:0] hr);
        logic [7:0] e_rd;
        logic       e_rv;
        @(negedge clk);
        req_valid = v; req_write = w; req_host = h; req_addr = a; req_wdata = d;
        tick_1ms = tk; dbg_disable = dbg; pwr_good = pg; host_rst = hr;
        e_rv = v && !w;
        e_rd = e_rv ? exp_read(int'(h), a) : 8'h00;
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            if (!pg || hr[i]) model_reset(i);
            else begin
                logic wr_i, trig, step;
                int   reload;
                wr_i   = v && w && (int'(h) == i);
                trig   = wr_i && (a == 8'h18);
                reload = int'({m_msb[i], m_hold[i], d});
                step   = m_en[i] && !m_exp[i] && tk && !dbg && !trig;
                if (wr_i) begin
                    if (a == 8'h18) m_cnt[i] = reload;
                    else if (a == 8'h19) begin
                        m_msb[i] = d[1:0];
                        if (d[7]) m_en[i] = 1'b1;
                    end else if (a == 8'h1A) m_hold[i] = d;
                end
                if (step) begin
                    if (m_cnt[i] <= 1) begin m_exp[i] = 1'b1; m_cnt[i] = 0; end
                    else m_cnt[i] = m_cnt[i] - 1;
                end
            end
        end
        #1;
        chk({7'b0, rd_valid}, {7'b0, e_rv}, "R10");
        if (e_rv) chk(rd_data, e_rd, $sformatf("%s R1", tag_for(a)));
        else      chk(rd_data, 8'h00, "R10");
        chk({6'b0, timeout}, {6'b0, (dbg ? 1'b0 : m_exp[1]), (dbg ? 1'b0 : m_exp[0])},
            dbg ? "R9" : "R7 R6 R1");
    endtask

    task automatic wr(logic h, logic [7:0] a, logic [7:0] d);
        cyc(1, 1, h, a, d, 0, dbg_disable, 1, 2'b00);
    endtask
    task automatic rd(logic h, logic [7:0] a);
        cyc(1, 0, h, a, 8'h00, 0, dbg_disable, 1, 2'b00);
    endtask
    task automatic ticks(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 8'h00, 8'h00, 1, dbg_disable, 1, 2'b00);
    endtask

    // Watchdog: a hung run is a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 0; pwr_good = 1; host_rst = 0; tick_1ms = 0; dbg_disable = 0;
        req_valid = 0; req_write = 0; req_host = 0; req_addr = 0; req_wdata = 0;
        for (int i = 0; i < 2; i++) model_reset(i);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R3 R4 R5 R2 R10: reset values visible on both hosts
        ctx = "R3 reset defaults";
        for (int h = 0; h < 2; h++) begin
            rd(h[0], 8'h19); rd(h[0], 8'h1A); rd(h[0], 8'h18); rd(h[0], 8'h1B);
        end

        // R8: trigger while disabled loads but does not count
        ctx = "R8 trigger while disabled";
        wr(0, 8'h1A, 8'h00); wr(0, 8'h19, 8'h00); wr(0, 8'h18, 8'h03);
        ticks(5);
        // R4: enable set; R6 R7: fires on third tick
        ctx = "R4 R6 R7 count of three";
        wr(0, 8'h19, 8'h80); rd(0, 8'h19);
        ticks(3);
        // R1: other host unaffected
        ctx = "R1 other bank untouched";
        rd(1, 8'h19); rd(1, 8'h1A);
        // R4: writing zero does not clear enable
        ctx = "R4 write zero ignored";
        wr(0, 8'h19, 8'h00); rd(0, 8'h19);
        // R7: trigger does not clear expiry
        ctx = "R7 sticky over trigger";
        wr(0, 8'h18, 8'h05); ticks(1);
        // R4 R7: host reset clears only its own bank
        ctx = "R4 host reset";
        cyc(0, 0, 0, 8'h00, 8'h00, 0, 0, 1, 2'b01);
        rd(0, 8'h19);

        // R11: retrigger while enabled restarts the count
        ctx = "R11 retrigger";
        wr(1, 8'h1A, 8'h00); wr(1, 8'h19, 8'h80); wr(1, 8'h18, 8'h04);
        ticks(3); wr(1, 8'h18, 8'h02); ticks(1); ticks(1);
        cyc(0, 0, 0, 8'h00, 8'h00, 0, 0, 0, 2'b00);   // R4 power-good loss

        // R9: debug strap freezes and masks
        ctx = "R9 debug strap";
        wr(1, 8'h1A, 8'h00); wr(1, 8'h19, 8'h80); wr(1, 8'h18, 8'h01);
        dbg_disable = 1; ticks(4);
        dbg_disable = 0; ticks(1);
        dbg_disable = 1; ticks(1);
        dbg_disable = 0; ticks(1);
        // R6: zero load fires on the first tick
        ctx = "R6 zero load";
        wr(0, 8'h1A, 8'h00); wr(0, 8'h19, 8'h80); wr(0, 8'h18, 8'h00); ticks(1);

        // Constrained random mix over all requirements
        ctx = "random R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11";
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic       v, w, h, tk, dbg, pg;
            logic [1:0] hr;
            logic [7:0] a, d;
            int         sel;
            v   = ($urandom % 3) != 0;
            w   = $urandom % 2;
            h   = $urandom % 2;
            sel = $urandom % 4;
            a   = (sel == 0) ? 8'h18 : (sel == 1) ? 8'h19 : (sel == 2) ? 8'h1A : 8'($urandom % 256);
            if (a == 8'h18)      d = 8'($urandom % 6);
            else if (a == 8'h19) d = {(($urandom % 4) == 0), 5'($urandom),
                                     (($urandom % 8) == 0) ? 2'($urandom) : 2'b00};
            else if (a == 8'h1A) d = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            else                 d = 8'($urandom);
            tk  = ($urandom % 3) == 0;
            dbg = ($urandom % 16) == 0;
            pg  = ($urandom % 300) != 0;
            hr  = {(($urandom % 150) == 0), (($urandom % 150) == 0)};
            cyc(v, w, h, a, d, tk, dbg, pg, hr);
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule